// File: doc/BRIEF.md
# USB Endpoint Completion Flags and Control Endpoint Stall Register

This block keeps two software-visible words for a USB device controller. The first word collects per-endpoint transfer-complete flags: a one-cycle pulse from the packet engine on a receive-done or transmit-done line sets the matching flag, and software acknowledges flags by writing ones to them. The second word holds the stall request for the control endpoint (endpoint 0), plus two fixed fields that always report a control-type endpoint that is enabled.

The stall request is managed by a small state machine with three states. ST_CLEAR means the endpoint answers normally. ST_STALLED means the endpoint answers every host token with a STALL handshake. ST_SETUP_HOLD means a SETUP packet has arrived and the stall request is held off. The transitions are as follows. "arm" goes from ST_CLEAR to ST_STALLED when software writes 1 to the stall bit. "disarm" goes from ST_STALLED to ST_CLEAR when software writes 0 to it. "setup_flush" goes from any state to ST_SETUP_HOLD on a SETUP-received pulse. "release" goes from ST_SETUP_HOLD to ST_CLEAR once the surrounding controller drops its setup-status pending flag. While the block is in ST_SETUP_HOLD, software writes to the stall bit are discarded.

Access uses a simple synchronous port: a word address, a write strobe, 32-bit write data, and a registered read word that appears one cycle after the address is presented. The stall output to the protocol engine comes straight from the state register.

Top module: `usb_ep_evt_regs`

## Requirements
- R1: After reset, every completion flag reads 0, the stall output is 0, and the control word reads 0x00000080.
- R2: A pulse on rx_done_i[n] sets bit n of the completion word (word address 0). A pulse on tx_done_i[n] sets bit 16+n. All other bits of that word read 0.
- R3: Writing to word address 0 clears each completion flag whose write-data bit is 1. Flags whose write-data bit is 0 keep their value.
- R4: When a done pulse and a write-one-to-clear hit the same flag in the same cycle, the flag ends up set.
- R5: Writing 1 to bit 0 of the control word (word address 1) raises ep0_stall_o from the next cycle. Writing 0 to that bit lowers it.
- R6: A setup_rx_i pulse drives ep0_stall_o low from the next cycle. This holds even when software writes 1 to the stall bit in that same cycle.
- R7: After a SETUP pulse, writes of 1 to the stall bit have no effect for as long as setup_pend_i stays high, and also in the first cycle after it falls. From then on, a write of 1 sets the stall again.
- R8: The control word reads bit 7 = 1, bits 3:2 = 0, bit 0 = the stall state, and all other bits 0. Writes cannot change the fixed bits.
- R9: rd_data_o shows the word selected by addr_i one clock edge later. Any address other than 0 or 1 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| addr_i | input | 4 | Word address for read and write |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Registered read data |
| rx_done_i | input | 4 | Receive-complete pulses, one per OUT endpoint |
| tx_done_i | input | 4 | Transmit-complete pulses, one per IN endpoint |
| setup_rx_i | input | 1 | SETUP packet received pulse |
| setup_pend_i | input | 1 | Setup-status pending flag from the controller |
| ep0_stall_o | output | 1 | Stall request to the protocol engine |

## Verification
Two collisions matter here, and each is provoked with a single combined drive on one falling edge. The first is a done pulse and a software clear landing on the same completion flag. The bench clears two flags while pulsing only one of them, then reads back to confirm that only the unpulsed flag was cleared. The second is a SETUP pulse arriving together with a software write of 1 to the stall bit. The bench confirms that the stall output is low on the next cycle, and that writes keep being discarded until the pending flag has dropped.

// File: rtl/usb_ep_evt_pkg.sv
package usb_ep_evt_pkg;

    // Control word field positions.
    localparam int unsigned CTRL_STALL_BIT = 0;
    localparam int unsigned CTRL_TYPE_LSB  = 2;
    localparam int unsigned CTRL_TYPE_W    = 2;
    localparam int unsigned CTRL_EN_BIT    = 7;

    // Fixed endpoint type code for a control endpoint.
    localparam logic [CTRL_TYPE_W-1:0] EP_TYPE_CONTROL = '0;

    typedef enum logic [1:0] {
        ST_CLEAR      = 2'd0,
        ST_STALLED    = 2'd1,
        ST_SETUP_HOLD = 2'd2
    } ep0_stall_st_e;

endpackage

// File: rtl/usb_ep_cmpl_flags.sv
module usb_ep_cmpl_flags #(
    parameter int unsigned NUM_EP = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [NUM_EP-1:0] set_i,
    input  logic              clr_en_i,
    input  logic [NUM_EP-1:0] clr_mask_i,
    output logic [NUM_EP-1:0] flags_o
);

    logic [NUM_EP-1:0] flag_q;

    for (genvar n = 0; n < NUM_EP; n++) begin : g_flag
        logic flag_d;

        // A set event has priority over a clear in the same cycle.
        always_comb begin
            flag_d = flag_q[n];
            if (clr_en_i && clr_mask_i[n]) begin
                flag_d = 1'b0;
            end
            if (set_i[n]) begin
                flag_d = 1'b1;
            end
        end

        always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
                flag_q[n] <= 1'b0;
            end else begin
                flag_q[n] <= flag_d;
            end
        end
    end

    assign flags_o = flag_q;

endmodule

// File: rtl/usb_ep0_stall_ctl.sv
module usb_ep0_stall_ctl
    import usb_ep_evt_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic ctrl_wr_i,
    input  logic ctrl_wr_stall_i,
    input  logic setup_rx_i,
    input  logic setup_pend_i,
    output logic stall_o
);

    ep0_stall_st_e state_q;
    ep0_stall_st_e state_d;

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_CLEAR: begin
                if (setup_rx_i) begin
                    state_d = ST_SETUP_HOLD;          // setup_flush
                end else if (ctrl_wr_i && ctrl_wr_stall_i) begin
                    state_d = ST_STALLED;             // arm
                end
            end
            ST_STALLED: begin
                if (setup_rx_i) begin
                    state_d = ST_SETUP_HOLD;          // setup_flush
                end else if (ctrl_wr_i && !ctrl_wr_stall_i) begin
                    state_d = ST_CLEAR;               // disarm
                end
            end
            ST_SETUP_HOLD: begin
                if (setup_rx_i) begin
                    state_d = ST_SETUP_HOLD;          // setup_flush again
                end else if (!setup_pend_i) begin
                    state_d = ST_CLEAR;               // release
                end
            end
            default: begin
                state_d = ST_CLEAR;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= ST_CLEAR;
        end else begin
            state_q <= state_d;
        end
    end

    // Output decode, taken from the state register only.
    always_comb begin
        stall_o = 1'b0;
        unique case (state_q)
            ST_STALLED:    stall_o = 1'b1;
            ST_CLEAR,
            ST_SETUP_HOLD: stall_o = 1'b0;
            default:       stall_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/usb_ep_rd_mux.sv
module usb_ep_rd_mux
    import usb_ep_evt_pkg::*;
#(
    parameter int unsigned NUM_EP    = 4,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned ADDR_W    = 4,
    parameter int unsigned CMPL_ADDR = 0,
    parameter int unsigned CTRL_ADDR = 1,
    parameter int unsigned TX_LSB    = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [NUM_EP-1:0] rx_flags_i,
    input  logic [NUM_EP-1:0] tx_flags_i,
    input  logic              stall_i,
    output logic [DATA_W-1:0] rd_data_o
);

    localparam logic [ADDR_W-1:0] CMPL_A = ADDR_W'(CMPL_ADDR);
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

    logic [DATA_W-1:0] cmpl_word;
    logic [DATA_W-1:0] ctrl_word;
    logic [DATA_W-1:0] rd_d;
    logic [DATA_W-1:0] rd_q;

    always_comb begin
        cmpl_word = '0;
        for (int n = 0; n < int'(NUM_EP); n++) begin
            cmpl_word[n]          = rx_flags_i[n];
            cmpl_word[TX_LSB + n] = tx_flags_i[n];
        end
    end

    always_comb begin
        ctrl_word = '0;
        ctrl_word[CTRL_STALL_BIT] = stall_i;
        ctrl_word[CTRL_TYPE_LSB +: CTRL_TYPE_W] = EP_TYPE_CONTROL;
        ctrl_word[CTRL_EN_BIT] = 1'b1;
    end

    always_comb begin
        if (addr_i == CMPL_A) begin
            rd_d = cmpl_word;
        end else if (addr_i == CTRL_A) begin
            rd_d = ctrl_word;
        end else begin
            rd_d = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rd_data_o = rd_q;

endmodule

// File: rtl/usb_ep_evt_regs.sv
module usb_ep_evt_regs
    import usb_ep_evt_pkg::*;
#(
    parameter int unsigned NUM_EP    = 4,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned ADDR_W    = 4,
    parameter int unsigned CMPL_ADDR = 0,
    parameter int unsigned CTRL_ADDR = 1,
    parameter int unsigned TX_LSB    = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [DATA_W-1:0] rd_data_o,
    input  logic [NUM_EP-1:0] rx_done_i,
    input  logic [NUM_EP-1:0] tx_done_i,
    input  logic              setup_rx_i,
    input  logic              setup_pend_i,
    output logic              ep0_stall_o
);

    localparam logic [ADDR_W-1:0] CMPL_A = ADDR_W'(CMPL_ADDR);
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

    logic              cmpl_wr;
    logic              ctrl_wr;
    logic [NUM_EP-1:0] cmpl_rx_q;
    logic [NUM_EP-1:0] cmpl_tx_q;
    logic              stall_q;
    logic              unused_wdata;

    assign cmpl_wr = wr_en_i && (addr_i == CMPL_A);
    assign ctrl_wr = wr_en_i && (addr_i == CTRL_A);

    // Write-data bits that no register uses.
    assign unused_wdata = ^wr_data_i;

    usb_ep_cmpl_flags #(
        .NUM_EP (NUM_EP)
    ) u_rx_flags (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .set_i      (rx_done_i),
        .clr_en_i   (cmpl_wr),
        .clr_mask_i (wr_data_i[NUM_EP-1:0]),
        .flags_o    (cmpl_rx_q)
    );

    usb_ep_cmpl_flags #(
        .NUM_EP (NUM_EP)
    ) u_tx_flags (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .set_i      (tx_done_i),
        .clr_en_i   (cmpl_wr),
        .clr_mask_i (wr_data_i[TX_LSB +: NUM_EP]),
        .flags_o    (cmpl_tx_q)
    );

    usb_ep0_stall_ctl u_stall (
        .clk_i           (clk_i),
        .rst_ni          (rst_ni),
        .ctrl_wr_i       (ctrl_wr),
        .ctrl_wr_stall_i (wr_data_i[CTRL_STALL_BIT]),
        .setup_rx_i      (setup_rx_i),
        .setup_pend_i    (setup_pend_i),
        .stall_o         (stall_q)
    );

    usb_ep_rd_mux #(
        .NUM_EP    (NUM_EP),
        .DATA_W    (DATA_W),
        .ADDR_W    (ADDR_W),
        .CMPL_ADDR (CMPL_ADDR),
        .CTRL_ADDR (CTRL_ADDR),
        .TX_LSB    (TX_LSB)
    ) u_rd (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .addr_i     (addr_i),
        .rx_flags_i (cmpl_rx_q),
        .tx_flags_i (cmpl_tx_q),
        .stall_i    (stall_q),
        .rd_data_o  (rd_data_o)
    );

    assign ep0_stall_o = stall_q;

endmodule

// File: rtl/usb_ep_evt_regs_chk.sv
module usb_ep_evt_regs_chk #(
    parameter int unsigned NUM_EP    = 4,
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned ADDR_W    = 4,
    parameter int unsigned CMPL_ADDR = 0,
    parameter int unsigned CTRL_ADDR = 1,
    parameter int unsigned TX_LSB    = 16
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [ADDR_W-1:0] addr_i,
    input logic              wr_en_i,
    input logic [DATA_W-1:0] wr_data_i,
    input logic [DATA_W-1:0] rd_data_o,
    input logic [NUM_EP-1:0] rx_done_i,
    input logic [NUM_EP-1:0] tx_done_i,
    input logic              setup_rx_i,
    input logic              setup_pend_i,
    input logic              ep0_stall_o,
    input logic [NUM_EP-1:0] cmpl_rx_q,
    input logic [NUM_EP-1:0] cmpl_tx_q
);

    localparam logic [ADDR_W-1:0] CMPL_A = ADDR_W'(CMPL_ADDR);
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

    // Independent model of the post-SETUP hold window.
    logic lock_q;
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            lock_q <= 1'b0;
        end else begin
            lock_q <= setup_rx_i || (lock_q && setup_pend_i);
        end
    end

    p_rx_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rx_done_i != '0) |=> ((cmpl_rx_q & $past(rx_done_i)) == $past(rx_done_i)));

    p_w1c_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && addr_i == CMPL_A && rx_done_i == '0)
        |=> ((cmpl_rx_q & $past(wr_data_i[NUM_EP-1:0])) == '0));

    p_set_wins_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tx_done_i != '0) |=> ((cmpl_tx_q & $past(tx_done_i)) == $past(tx_done_i)));

    p_sw_stall_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && addr_i == CTRL_A && wr_data_i[0] && !setup_rx_i && !lock_q)
        |=> ep0_stall_o);

    p_setup_clr_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        setup_rx_i |=> !ep0_stall_o);

    p_hold_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        lock_q |-> !ep0_stall_o);

    p_ctrl_fixed_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (addr_i == CTRL_A) |=> (rd_data_o[7] && rd_data_o[3:2] == 2'b00));

    p_unmapped_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (addr_i != CTRL_A && addr_i != CMPL_A) |=> (rd_data_o == '0));

endmodule

bind usb_ep_evt_regs usb_ep_evt_regs_chk #(
    .NUM_EP    (NUM_EP),
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .CMPL_ADDR (CMPL_ADDR),
    .CTRL_ADDR (CTRL_ADDR),
    .TX_LSB    (TX_LSB)
) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .addr_i       (addr_i),
    .wr_en_i      (wr_en_i),
    .wr_data_i    (wr_data_i),
    .rd_data_o    (rd_data_o),
    .rx_done_i    (rx_done_i),
    .tx_done_i    (tx_done_i),
    .setup_rx_i   (setup_rx_i),
    .setup_pend_i (setup_pend_i),
    .ep0_stall_o  (ep0_stall_o),
    .cmpl_rx_q    (cmpl_rx_q),
    .cmpl_tx_q    (cmpl_tx_q)
);

// File: tb/usb_ep_evt_regs_bench.sv
`timescale 1ns/1ps
module usb_ep_evt_regs_bench;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic [3:0]  addr_i = '0;
    logic        wr_en_i = 1'b0;
    logic [31:0] wr_data_i = '0;
    logic [31:0] rd_data_o;
    logic [3:0]  rx_done_i = '0;
    logic [3:0]  tx_done_i = '0;
    logic        setup_rx_i = 1'b0;
    logic        setup_pend_i = 1'b0;
    logic        ep0_stall_o;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk_i = ~clk_i;

    usb_ep_evt_regs u_usb_ep_evt_regs (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .addr_i       (addr_i),
        .wr_en_i      (wr_en_i),
        .wr_data_i    (wr_data_i),
        .rd_data_o    (rd_data_o),
        .rx_done_i    (rx_done_i),
        .tx_done_i    (tx_done_i),
        .setup_rx_i   (setup_rx_i),
        .setup_pend_i (setup_pend_i),
        .ep0_stall_o  (ep0_stall_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // One cycle: drive on the falling edge, let a rising edge pass, return on the next falling edge.
    task automatic cycle_drive(input logic we, input logic [3:0] a, input logic [31:0] d,
                               input logic [3:0] rx, input logic [3:0] tx, input logic su);
        @(negedge clk_i);
        wr_en_i = we; addr_i = a; wr_data_i = d;
        rx_done_i = rx; tx_done_i = tx; setup_rx_i = su;
        @(negedge clk_i);
        wr_en_i = 1'b0; wr_data_i = '0; rx_done_i = '0; tx_done_i = '0; setup_rx_i = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        cycle_drive(1'b1, a, d, '0, '0, 1'b0);
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        @(negedge clk_i);
        addr_i = a; wr_en_i = 1'b0;
        @(negedge clk_i);
        v = rd_data_o;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        check("R1 stall after reset", 32'(ep0_stall_o), 32'h0);
        rd(4'd0, v); check("R1 completion word after reset", v, 32'h0);
        rd(4'd1, v); check("R1 control word after reset", v, 32'h80);
    endtask

    task automatic t_set_flags;
        logic [31:0] v;
        cycle_drive(1'b0, 4'd0, '0, 4'b0101, 4'b0000, 1'b0);
        rd(4'd0, v); check("R2 rx flags 0 and 2", v, 32'h0000_0005);
        cycle_drive(1'b0, 4'd0, '0, 4'b0000, 4'b1010, 1'b0);
        rd(4'd0, v); check("R2 tx flags 1 and 3", v, 32'h000A_0005);
        cycle_drive(1'b0, 4'd0, '0, 4'b1010, 4'b0101, 1'b0);
        rd(4'd0, v); check("R2 all flags", v, 32'h000F_000F);
    endtask

    task automatic t_w1c;
        logic [31:0] v;
        wr(4'd0, 32'h0003_0009);
        rd(4'd0, v); check("R3 partial clear", v, 32'h000C_0006);
        wr(4'd0, 32'h0);
        rd(4'd0, v); check("R3 zero write keeps flags", v, 32'h000C_0006);
        wr(4'd0, 32'hFFFF_FFFF);
        rd(4'd0, v); check("R3 full clear", v, 32'h0);
    endtask

    task automatic t_set_wins;
        logic [31:0] v;
        cycle_drive(1'b0, 4'd0, '0, 4'b0010, 4'b0100, 1'b0);
        // Clear rx1, rx0, tx2, tx3 while rx0 and tx3 pulse.
        cycle_drive(1'b1, 4'd0, 32'h000C_0003, 4'b0001, 4'b1000, 1'b0);
        rd(4'd0, v); check("R4 set beats clear", v, 32'h0008_0001);
        wr(4'd0, 32'hFFFF_FFFF);
    endtask

    task automatic t_sw_stall;
        logic [31:0] v;
        wr(4'd1, 32'h1);
        check("R5 stall raised", 32'(ep0_stall_o), 32'h1);
        rd(4'd1, v); check("R8 control word stalled", v, 32'h81);
        wr(4'd1, 32'h0);
        check("R5 stall lowered", 32'(ep0_stall_o), 32'h0);
        wr(4'd1, 32'hFFFF_FF7E);
        rd(4'd1, v); check("R8 fixed bits unchanged by write", v, 32'h80);
    endtask

    task automatic t_setup_clear;
        wr(4'd1, 32'h1);
        check("R6 armed before setup", 32'(ep0_stall_o), 32'h1);
        cycle_drive(1'b0, 4'd0, '0, '0, '0, 1'b1);
        check("R6 setup clears stall", 32'(ep0_stall_o), 32'h0);
        repeat (2) @(negedge clk_i);
        // SETUP and write of 1 in the same cycle.
        cycle_drive(1'b1, 4'd1, 32'h1, '0, '0, 1'b1);
        check("R6 setup beats write", 32'(ep0_stall_o), 32'h0);
        repeat (2) @(negedge clk_i);
    endtask

    task automatic t_hold;
        logic [31:0] v;
        @(negedge clk_i); setup_pend_i = 1'b1;
        cycle_drive(1'b0, 4'd0, '0, '0, '0, 1'b1);
        wr(4'd1, 32'h1);
        check("R7 write ignored while pending", 32'(ep0_stall_o), 32'h0);
        wr(4'd1, 32'h1);
        rd(4'd1, v); check("R7 control word while pending", v, 32'h80);
        @(negedge clk_i); setup_pend_i = 1'b0;
        @(negedge clk_i);
        wr(4'd1, 32'h1);
        check("R7 write effective after release", 32'(ep0_stall_o), 32'h1);
        wr(4'd1, 32'h0);
    endtask

    task automatic t_unmapped;
        logic [31:0] v;
        cycle_drive(1'b0, 4'd0, '0, 4'b1111, 4'b1111, 1'b0);
        rd(4'd2, v); check("R9 unmapped address 2", v, 32'h0);
        rd(4'd15, v); check("R9 unmapped address 15", v, 32'h0);
        // Latency: the word follows the address one edge later.
        @(negedge clk_i); addr_i = 4'd0;
        @(negedge clk_i); addr_i = 4'd1;
        check("R9 first word after one edge", rd_data_o, 32'h000F_000F);
        @(negedge clk_i);
        check("R9 second word after one edge", rd_data_o, 32'h80);
    endtask

    initial begin
        repeat (100000) @(posedge clk_i);
        n_bad++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);
        t_reset();
        t_set_flags();
        t_w1c();
        t_set_wins();
        t_sw_stall();
        t_setup_clear();
        t_hold();
        t_unmapped();
        repeat (2) @(negedge clk_i);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule